// File: doc/BRIEF.md
# Step Counter with Optional Count Limit

This block is a parameterized synchronous binary counter. At build time it is fixed to count upward, downward, or in a direction chosen at run time by an input pin. Each enabled clock moves the count by a fixed step that can be any non-zero value.

A restricted variant stops at a programmed limit. The limit is found by an exact equality compare, and on the clock after the count equals the limit the count returns to zero. A combinational flag goes high while the count equals a programmable threshold.

The counter also has the following synchronous controls:
- clear, which forces zero;
- preset, which forces all ones;
- re-initialise, which forces a parameter value;
- a parallel load, whose strobe polarity is a parameter.

Parameters decide whether a control is present, whether clear or preset wins when both are high, and whether the controls need the clock enable. An asynchronous active-low reset puts the count at a configurable power-on value. In a restricted counter, a count that lands off the step grid that passes through the limit makes the checker print a note.

Top module: `step_counter`

## Requirements
- R1: While rst_ni is low, count_o equals the POR_VAL parameter, and it keeps that value until the first enabled edge after release.
- R2: When the counter is unrestricted, each enabled edge adds STEP to the count modulo 2^WIDTH, or subtracts it modulo 2^WIDTH. In the up/down mode, dir_up_i high selects add and low selects subtract.
- R3: A restricted up counter adds STEP on each enabled edge until count_o equals LIMIT. On the next enabled edge count_o becomes 0.
- R4: A restricted down counter subtracts STEP until count_o equals LIMIT. On the next enabled edge count_o becomes 0, and later edges keep subtracting STEP modulo 2^WIDTH.
- R5: The limit is detected only by equality. A loaded value above LIMIT in an up counter keeps stepping past LIMIT and does not return to 0.
- R6: With clear_i and preset_i both effective, count_o becomes 0 when CLEAR_WINS=1 and becomes all ones when CLEAR_WINS=0.
- R7: An effective reinit_i puts REINIT_VAL into the count at the next edge.
- R8: An effective clear, preset or reinit takes priority over a load that is active in the same cycle.
- R9: With SYNC_IGNORES_CE=1, clear, preset and reinit act while cnt_en_i is low. With SYNC_IGNORES_CE=0, they have no effect while cnt_en_i is low, and the count holds.
- R10: When cnt_en_i is high and load_i is at its active level, load_val_i enters the count at the next edge. The active level is high when LOAD_ACT_HIGH=1 and low when LOAD_ACT_HIGH=0. A load is ignored while cnt_en_i is low.
- R11: When cnt_en_i is low and no effective synchronous control is present, the count holds.
- R12: thresh_o is high exactly while count_o equals THRESH, in the same cycle and with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset to POR_VAL |
| cnt_en_i | input | 1 | Clock enable for stepping and load |
| dir_up_i | input | 1 | Direction in up/down mode (1 = up) |
| clear_i | input | 1 | Synchronous clear to zero |
| preset_i | input | 1 | Synchronous preset to all ones |
| reinit_i | input | 1 | Synchronous re-initialise to REINIT_VAL |
| load_i | input | 1 | Load strobe, polarity set by LOAD_ACT_HIGH |
| load_val_i | input | WIDTH | Parallel load word |
| count_o | output | WIDTH | Current count |
| thresh_o | output | 1 | High while count equals THRESH |

## Verification
The bench looks for cycles where a synchronous control and a load, or clear and preset, are all active together. It raises clear with load, reinit with load, and clear with preset at the same edge, and checks that the count lands on the winner's value and not on the load word. It also drops the clock enable under clear and preset, and checks that the counter clears in the setting that ignores the enable and holds in the setting that obeys it.

// File: rtl/sc_pkg.sv
package sc_pkg;

  typedef enum logic [1:0] {
    MODE_UP     = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_UPDOWN = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    ACT_HOLD   = 3'd0,
    ACT_STEP   = 3'd1,
    ACT_LOAD   = 3'd2,
    ACT_CLEAR  = 3'd3,
    ACT_PRESET = 3'd4,
    ACT_REINIT = 3'd5
  } act_e;

endpackage

// File: rtl/sc_match.sv
module sc_match #(
  parameter int unsigned          WIDTH = 8,
  parameter logic [WIDTH-1:0]     VALUE = '0
) (
  input  logic [WIDTH-1:0] value_i,
  output logic             hit_o
);

  always_comb begin
    hit_o = (value_i == VALUE);
  end

endmodule

// File: rtl/sc_arbiter.sv
module sc_arbiter #(
  parameter bit HAS_CLEAR       = 1'b1,
  parameter bit HAS_PRESET      = 1'b0,
  parameter bit HAS_REINIT      = 1'b0,
  parameter bit CLEAR_WINS      = 1'b1,
  parameter bit SYNC_IGNORES_CE = 1'b1,
  parameter bit LOAD_ACT_HIGH   = 1'b1
) (
  input  logic         cnt_en_i,
  input  logic         clear_i,
  input  logic         preset_i,
  input  logic         reinit_i,
  input  logic         load_i,
  output sc_pkg::act_e act_o
);

  logic sync_gate;
  logic clr_eff;
  logic pre_eff;
  logic ini_eff;
  logic ld_eff;

  always_comb begin
    sync_gate = SYNC_IGNORES_CE | cnt_en_i;
    clr_eff   = HAS_CLEAR  & clear_i  & sync_gate;
    pre_eff   = HAS_PRESET & preset_i & sync_gate;
    ini_eff   = HAS_REINIT & reinit_i & sync_gate;
    ld_eff    = cnt_en_i & (LOAD_ACT_HIGH ? load_i : ~load_i);
  end

  always_comb begin
    act_o = sc_pkg::ACT_HOLD;
    if (clr_eff && pre_eff) begin
      act_o = CLEAR_WINS ? sc_pkg::ACT_CLEAR : sc_pkg::ACT_PRESET;
    end else if (clr_eff) begin
      act_o = sc_pkg::ACT_CLEAR;
    end else if (pre_eff) begin
      act_o = sc_pkg::ACT_PRESET;
    end else if (ini_eff) begin
      act_o = sc_pkg::ACT_REINIT;
    end else if (ld_eff) begin
      act_o = sc_pkg::ACT_LOAD;
    end else if (cnt_en_i) begin
      act_o = sc_pkg::ACT_STEP;
    end
  end

endmodule

// File: rtl/sc_stepper.sv
module sc_stepper #(
  parameter int unsigned      WIDTH    = 8,
  parameter sc_pkg::mode_e    MODE     = sc_pkg::MODE_UP,
  parameter bit               RESTRICT = 1'b1,
  parameter logic [WIDTH-1:0] STEP     = WIDTH'(3),
  parameter logic [WIDTH-1:0] LIMIT    = WIDTH'(30)
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic             dir_up_i,
  output logic [WIDTH-1:0] next_o
);

  logic at_limit;
  logic go_up;

  generate
    if (RESTRICT) begin : g_limit
      sc_match #(
        .WIDTH (WIDTH),
        .VALUE (LIMIT)
      ) u_limit (
        .value_i (count_i),
        .hit_o   (at_limit)
      );
    end else begin : g_free
      assign at_limit = 1'b0;
    end
  endgenerate

  always_comb begin
    case (MODE)
      sc_pkg::MODE_UP:     go_up = 1'b1;
      sc_pkg::MODE_DOWN:   go_up = 1'b0;
      default:             go_up = dir_up_i;
    endcase
  end

  always_comb begin
    if (at_limit) begin
      next_o = '0;
    end else if (go_up) begin
      next_o = count_i + STEP;
    end else begin
      next_o = count_i - STEP;
    end
  end

endmodule

// File: rtl/step_counter.sv
module step_counter #(
  parameter int unsigned      WIDTH           = 8,
  parameter sc_pkg::mode_e    MODE            = sc_pkg::MODE_UP,
  parameter bit               RESTRICT        = 1'b1,
  parameter logic [WIDTH-1:0] STEP            = WIDTH'(3),
  parameter logic [WIDTH-1:0] LIMIT           = WIDTH'(30),
  parameter logic [WIDTH-1:0] THRESH          = WIDTH'(12),
  parameter logic [WIDTH-1:0] POR_VAL         = '0,
  parameter logic [WIDTH-1:0] REINIT_VAL      = '0,
  parameter bit               HAS_CLEAR       = 1'b1,
  parameter bit               HAS_PRESET      = 1'b0,
  parameter bit               HAS_REINIT      = 1'b0,
  parameter bit               CLEAR_WINS      = 1'b1,
  parameter bit               SYNC_IGNORES_CE = 1'b1,
  parameter bit               LOAD_ACT_HIGH   = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             dir_up_i,
  input  logic             clear_i,
  input  logic             preset_i,
  input  logic             reinit_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic [WIDTH-1:0] count_o,
  output logic             thresh_o
);

  localparam longint unsigned SPAN  = 64'd1 << WIDTH;
  localparam longint unsigned STEPL = 64'(STEP);
  localparam longint unsigned LIML  = 64'(LIMIT);

  generate
    if (STEPL == 0) begin : g_bad_step
      initial $error("step_counter: STEP must be non-zero");
    end
    if (RESTRICT && (MODE == sc_pkg::MODE_UPDOWN || HAS_PRESET)) begin : g_bad_mix
      initial $error("step_counter: limit cannot combine with up/down or preset");
    end
    if (RESTRICT && MODE == sc_pkg::MODE_UP && STEPL != 0 &&
        ((LIML % STEPL) != 0 || STEPL > LIML)) begin : g_bad_up
      initial $error("step_counter: LIMIT must be a multiple of STEP and not below it");
    end
    if (RESTRICT && MODE == sc_pkg::MODE_DOWN && STEPL != 0 &&
        (((SPAN - LIML) % STEPL) != 0 || STEPL > SPAN - LIML)) begin : g_bad_down
      initial $error("step_counter: distance from LIMIT to wrap must be a multiple of STEP");
    end
    if (HAS_REINIT && (HAS_CLEAR || HAS_PRESET)) begin : g_bad_init
      initial $error("step_counter: reinit cannot coexist with clear or preset");
    end
  endgenerate

  sc_pkg::act_e     act;
  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_d;
  logic [WIDTH-1:0] step_nxt;

  sc_arbiter #(
    .HAS_CLEAR       (HAS_CLEAR),
    .HAS_PRESET      (HAS_PRESET),
    .HAS_REINIT      (HAS_REINIT),
    .CLEAR_WINS      (CLEAR_WINS),
    .SYNC_IGNORES_CE (SYNC_IGNORES_CE),
    .LOAD_ACT_HIGH   (LOAD_ACT_HIGH)
  ) u_arb (
    .cnt_en_i (cnt_en_i),
    .clear_i  (clear_i),
    .preset_i (preset_i),
    .reinit_i (reinit_i),
    .load_i   (load_i),
    .act_o    (act)
  );

  sc_stepper #(
    .WIDTH    (WIDTH),
    .MODE     (MODE),
    .RESTRICT (RESTRICT),
    .STEP     (STEP),
    .LIMIT    (LIMIT)
  ) u_step (
    .count_i  (count_q),
    .dir_up_i (dir_up_i),
    .next_o   (step_nxt)
  );

  sc_match #(
    .WIDTH (WIDTH),
    .VALUE (THRESH)
  ) u_thresh (
    .value_i (count_q),
    .hit_o   (thresh_o)
  );

  always_comb begin
    case (act)
      sc_pkg::ACT_CLEAR:  count_d = '0;
      sc_pkg::ACT_PRESET: count_d = '1;
      sc_pkg::ACT_REINIT: count_d = REINIT_VAL;
      sc_pkg::ACT_LOAD:   count_d = load_val_i;
      sc_pkg::ACT_STEP:   count_d = step_nxt;
      default:            count_d = count_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= POR_VAL;
    end else begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/sc_chk.sv
module sc_chk #(
  parameter int unsigned      WIDTH           = 8,
  parameter sc_pkg::mode_e    MODE            = sc_pkg::MODE_UP,
  parameter bit               RESTRICT        = 1'b1,
  parameter logic [WIDTH-1:0] STEP            = WIDTH'(3),
  parameter logic [WIDTH-1:0] LIMIT           = WIDTH'(30),
  parameter logic [WIDTH-1:0] THRESH          = WIDTH'(12),
  parameter bit               HAS_CLEAR       = 1'b1,
  parameter bit               HAS_PRESET      = 1'b0,
  parameter bit               HAS_REINIT      = 1'b0,
  parameter bit               CLEAR_WINS      = 1'b1,
  parameter bit               SYNC_IGNORES_CE = 1'b1,
  parameter bit               LOAD_ACT_HIGH   = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_en_i,
  input logic             dir_up_i,
  input logic             clear_i,
  input logic             preset_i,
  input logic             reinit_i,
  input logic             load_i,
  input logic [WIDTH-1:0] load_val_i,
  input logic [WIDTH-1:0] count_o,
  input logic             thresh_o
);

  logic gate;
  logic any_sync;
  logic ld_on;
  logic clr_only;
  logic [WIDTH-1:0] prev_q;
  logic             seen_q;
  logic             off_grid;

  always_comb begin
    gate     = SYNC_IGNORES_CE | cnt_en_i;
    any_sync = gate & ((HAS_CLEAR & clear_i) | (HAS_PRESET & preset_i) |
                       (HAS_REINIT & reinit_i));
    ld_on    = LOAD_ACT_HIGH ? load_i : ~load_i;
    clr_only = gate & HAS_CLEAR & clear_i & ~(HAS_PRESET & preset_i & ~CLEAR_WINS);
    if (MODE == sc_pkg::MODE_DOWN) begin
      off_grid = ((WIDTH'(0) - count_o) % STEP) != '0;
    end else begin
      off_grid = (count_o % STEP) != '0;
    end
  end

  // R11: no enable and no control keeps the count
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !any_sync) |=> $stable(count_o));

  // R6: an effective clear that is not overruled gives zero
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_only |=> (count_o == '0));

  // R3: reaching the limit returns to zero on the next stepping edge
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (RESTRICT && count_o == LIMIT && cnt_en_i && !any_sync && !ld_on)
    |=> (count_o == '0));

  // R10: an accepted load delivers the load word
  p_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && ld_on && !any_sync) |=> (count_o == $past(load_val_i)));

  // R12: flag tracks equality with the threshold
  p_thresh_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thresh_o == (count_o == THRESH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= count_o;
      seen_q <= 1'b1;
      if (RESTRICT && seen_q && count_o != prev_q && off_grid) begin
        $display("note: count %0h is off the step grid, limit %0h may be skipped",
                 count_o, LIMIT);
      end
    end
  end

endmodule

bind step_counter sc_chk #(
  .WIDTH           (WIDTH),
  .MODE            (MODE),
  .RESTRICT        (RESTRICT),
  .STEP            (STEP),
  .LIMIT           (LIMIT),
  .THRESH          (THRESH),
  .HAS_CLEAR       (HAS_CLEAR),
  .HAS_PRESET      (HAS_PRESET),
  .HAS_REINIT      (HAS_REINIT),
  .CLEAR_WINS      (CLEAR_WINS),
  .SYNC_IGNORES_CE (SYNC_IGNORES_CE),
  .LOAD_ACT_HIGH   (LOAD_ACT_HIGH)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnt_en_i   (cnt_en_i),
  .dir_up_i   (dir_up_i),
  .clear_i    (clear_i),
  .preset_i   (preset_i),
  .reinit_i   (reinit_i),
  .load_i     (load_i),
  .load_val_i (load_val_i),
  .count_o    (count_o),
  .thresh_o   (thresh_o)
);

// File: tb/step_counter_tb_top.sv
module step_counter_tb_top;

  logic clk;
  logic rst_n;
  int   n_chk;
  int   n_bad;

  // dut_i: restricted up, step 3, limit 30, threshold 12, clear only
  logic       a_ce, a_clr, a_ld;
  logic [7:0] a_val, a_cnt;
  logic       a_thr;

  // dut_u: free up/down, step 5, preset wins, controls need enable, load active low
  logic       u_ce, u_dir, u_clr, u_pre, u_ld;
  logic [7:0] u_val, u_cnt;
  logic       u_thr;

  // dut_n: restricted down, step 4, limit F0, reinit F8
  logic       n_ce, n_ini, n_ld;
  logic [7:0] n_val, n_cnt;
  logic       n_thr;

  step_counter dut_i (
    .clk_i (clk), .rst_ni (rst_n), .cnt_en_i (a_ce), .dir_up_i (1'b1),
    .clear_i (a_clr), .preset_i (1'b0), .reinit_i (1'b0), .load_i (a_ld),
    .load_val_i (a_val), .count_o (a_cnt), .thresh_o (a_thr)
  );

  step_counter #(
    .MODE (sc_pkg::MODE_UPDOWN), .RESTRICT (1'b0), .STEP (8'd5),
    .THRESH (8'h15), .POR_VAL (8'h10), .HAS_CLEAR (1'b1), .HAS_PRESET (1'b1),
    .CLEAR_WINS (1'b0), .SYNC_IGNORES_CE (1'b0), .LOAD_ACT_HIGH (1'b0)
  ) dut_u (
    .clk_i (clk), .rst_ni (rst_n), .cnt_en_i (u_ce), .dir_up_i (u_dir),
    .clear_i (u_clr), .preset_i (u_pre), .reinit_i (1'b0), .load_i (u_ld),
    .load_val_i (u_val), .count_o (u_cnt), .thresh_o (u_thr)
  );

  step_counter #(
    .MODE (sc_pkg::MODE_DOWN), .RESTRICT (1'b1), .STEP (8'd4),
    .LIMIT (8'hF0), .THRESH (8'h00), .POR_VAL (8'hFC), .REINIT_VAL (8'hF8),
    .HAS_CLEAR (1'b0), .HAS_REINIT (1'b1)
  ) dut_n (
    .clk_i (clk), .rst_ni (rst_n), .cnt_en_i (n_ce), .dir_up_i (1'b0),
    .clear_i (1'b0), .preset_i (1'b0), .reinit_i (n_ini), .load_i (n_ld),
    .load_val_i (n_val), .count_o (n_cnt), .thresh_o (n_thr)
  );

  typedef struct packed {
    logic       ce;
    logic       clr;
    logic       ld;
    logic [7:0] val;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b0, 8'd0,  8'd3,  4'd3},   // R3 step
    '{1'b1, 1'b0, 1'b0, 8'd0,  8'd6,  4'd3},
    '{1'b1, 1'b0, 1'b0, 8'd0,  8'd9,  4'd3},
    '{1'b1, 1'b0, 1'b0, 8'd0,  8'd12, 4'd12},  // R12 threshold hit
    '{1'b0, 1'b0, 1'b0, 8'd0,  8'd12, 4'd11},  // R11 hold
    '{1'b1, 1'b0, 1'b1, 8'd27, 8'd27, 4'd10},  // R10 load
    '{1'b1, 1'b0, 1'b0, 8'd0,  8'd30, 4'd3},
    '{1'b1, 1'b0, 1'b0, 8'd0,  8'd0,  4'd3},   // R3 limit to zero
    '{1'b1, 1'b0, 1'b0, 8'd0,  8'd3,  4'd3},
    '{1'b0, 1'b1, 1'b0, 8'd0,  8'd0,  4'd9},   // R9 clear without enable
    '{1'b1, 1'b0, 1'b1, 8'd21, 8'd21, 4'd10},
    '{1'b1, 1'b1, 1'b1, 8'd9,  8'd0,  4'd8},   // R8 clear beats load
    '{1'b0, 1'b0, 1'b1, 8'd15, 8'd0,  4'd10},  // R10 load needs enable
    '{1'b1, 1'b0, 1'b1, 8'd31, 8'd31, 4'd5},
    '{1'b1, 1'b0, 1'b0, 8'd0,  8'd34, 4'd5},   // R5 past the limit
    '{1'b1, 1'b0, 1'b0, 8'd0,  8'd37, 4'd5}
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0;
    a_ce = 0; a_clr = 0; a_ld = 0; a_val = '0;
    u_ce = 0; u_dir = 1; u_clr = 0; u_pre = 0; u_ld = 1; u_val = '0;
    n_ce = 0; n_ini = 0; n_ld = 0; n_val = '0;
    #22;
    rst_n = 1'b1;
    #1;
    chk(a_cnt, 8'd0,  "R1 dut_i power-on");
    chk(u_cnt, 8'h10, "R1 dut_u power-on");
    chk(n_cnt, 8'hFC, "R1 dut_n power-on");
    chk({7'd0, u_thr}, 8'd0, "R12 dut_u flag low at 10");

    for (int k = 0; k < NV; k++) begin
      a_ce = VEC[k].ce; a_clr = VEC[k].clr; a_ld = VEC[k].ld; a_val = VEC[k].val;
      tick();
      n_chk++;
      if (a_cnt !== VEC[k].exp || a_thr !== (VEC[k].exp == 8'd12)) begin
        n_bad++;
        $display("FAIL R%0d vector %0d: actual %0h/%0b expected %0h/%0b", VEC[k].req,
                 k, a_cnt, a_thr, VEC[k].exp, (VEC[k].exp == 8'd12));
      end
    end
    a_ce = 0; a_clr = 0; a_ld = 0;

    // dut_u: up/down, polarity, preset priority, enable gating
    u_ce = 1; u_dir = 1; tick();
    chk(u_cnt, 8'h15, "R2 up by 5");
    chk({7'd0, u_thr}, 8'd1, "R12 flag at threshold");
    u_dir = 0; tick();
    chk(u_cnt, 8'h10, "R2 down by 5");
    u_ld = 0; u_val = 8'h02; tick();
    chk(u_cnt, 8'h02, "R10 active-low load");
    u_ld = 1; tick();
    chk(u_cnt, 8'hFD, "R2 down wraps modulo");
    u_dir = 1; tick();
    chk(u_cnt, 8'h02, "R2 up wraps modulo");
    u_ce = 0; u_clr = 1; u_pre = 1; tick();
    chk(u_cnt, 8'h02, "R9 controls ignored without enable");
    u_ce = 1; tick();
    chk(u_cnt, 8'hFF, "R6 preset wins over clear");
    u_clr = 0; u_pre = 0; tick();
    chk(u_cnt, 8'h04, "R2 step after preset");
    u_clr = 1; tick();
    chk(u_cnt, 8'h00, "R6 clear alone");
    u_clr = 0; u_ld = 1; u_val = 8'h77; tick();
    chk(u_cnt, 8'h05, "R10 high strobe is inactive");
    u_ce = 0;

    // dut_n: restricted down and reinit
    n_ce = 1; tick();
    chk(n_cnt, 8'hF8, "R4 down step");
    tick();
    chk(n_cnt, 8'hF4, "R4 down step");
    tick();
    chk(n_cnt, 8'hF0, "R4 reaches limit");
    tick();
    chk(n_cnt, 8'h00, "R4 limit to zero");
    chk({7'd0, n_thr}, 8'd1, "R12 zero threshold");
    tick();
    chk(n_cnt, 8'hFC, "R4 keeps counting down");
    tick();
    chk(n_cnt, 8'hF8, "R4 down step");
    tick();
    chk(n_cnt, 8'hF4, "R4 down step");
    n_ini = 1; n_ld = 1; n_val = 8'h10; tick();
    chk(n_cnt, 8'hF8, "R7 R8 reinit beats load");
    n_ini = 0; n_ld = 0; tick();
    chk(n_cnt, 8'hF4, "R4 step after reinit");
    n_ce = 0; n_ini = 1; tick();
    chk(n_cnt, 8'hF8, "R9 reinit without enable");
    n_ini = 0; tick();
    chk(n_cnt, 8'hF8, "R11 hold");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule